// File: doc/BRIEF.md
# MESI Snooping Line-State Controller

This block keeps the coherence state and tag of every line of a small direct-mapped write-back cache. It sits between the processor port and a snooping bus. Each processor read or write is resolved on the spot, or turned into exactly one bus request: a shared read, a read-for-ownership or an upgrade. Each snooped transaction can downgrade or invalidate the matching line and may cause the controller to supply the line. When a miss displaces a dirty line, the block raises a write-back request that carries the victim's line address.

The data array, bus arbitration and memory timing are outside the block. A granted bus request is modelled as one `bus_gnt` cycle, during which the shared-sense wire of the system is valid. Snoop responses are registered and appear in the cycle after the snoop is presented. A clean-exclusive state removes the second bus transaction from a read followed by a write to unshared data. Supply of clean exclusive lines cache to cache is a build-time option.

Top module: `mesi_line_ctl`

## Requirements
- R1: After reset every line is Invalid and `cpu_done`, `bus_req_valid`, `wb_valid`, `snp_shared`, `snp_flush` and `snp_flushopt` are low, so the first read of any address issues a bus read.
- R2: A read that hits a valid line with a matching tag raises `cpu_done` in the next cycle, issues no bus request and leaves the line state unchanged.
- R3: A read miss raises `bus_req_valid` with `bus_req_cmd` = 1 (shared read) and holds it until `bus_gnt`. The line fills to Exclusive if `bus_shared_in` is low during the grant cycle and to Shared if it is high, and `cpu_done` follows one cycle after the grant.
- R4: A write miss issues command 2 (read-for-ownership), and a write to a Shared line issues command 3 (upgrade). Either way the line becomes Modified at the grant.
- R5: A write that hits an Exclusive line makes it Modified with no bus request. A write that hits a Modified line leaves it Modified with no bus request.
- R6: A miss whose index holds a valid line of another tag evicts that line. If the victim was Modified, `wb_valid` pulses for one cycle, together with the first cycle of the bus request, with `wb_addr` = {victim tag, index}. An Exclusive or Shared victim causes no write-back.
- R7: A snooped shared read (command 1) that hits a valid line raises `snp_shared`. On a Modified line it also raises `snp_flush`, on an Exclusive line it raises `snp_flushopt`, and both lines become Shared. A Shared line stays Shared and supplies nothing.
- R8: A snooped read-for-ownership (2) or upgrade (3) that hits a valid line invalidates it. It raises `snp_flush` only if the line was Modified and never raises `snp_shared`.
- R9: Snooped flush (4) and optional flush (5) commands, and any snoop whose tag does not match a valid line, cause no response and change no state.
- R10: With `FLUSHOPT_EN` = 0, `snp_flushopt` never rises, and every other output and state transition is identical to the enabled build.
- R11: If a pending upgrade's line is invalidated by a snooped read-for-ownership or upgrade before the grant, the pending command changes to read-for-ownership from the next cycle, and the grant still fills the line Modified.
- R12: Snoop responses appear in the cycle after `snp_valid`. While idle, a processor request is not accepted in a cycle with `snp_valid` high, and it is taken in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until `cpu_done` |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address {tag, index} |
| cpu_done | output | 1 | One-cycle completion pulse |
| bus_req_valid | output | 1 | Bus request pending |
| bus_req_cmd | output | 3 | 1 shared read, 2 read-for-ownership, 3 upgrade |
| bus_req_addr | output | ADDR_W | Address of the pending request |
| bus_gnt | input | 1 | Pending request performed on the bus this cycle |
| bus_shared_in | input | 1 | System shared-sense, valid with `bus_gnt` |
| wb_valid | output | 1 | Dirty victim must be written back |
| wb_addr | output | ADDR_W | Line address of the dirty victim |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 3 | Snooped command: 1 rd, 2 rdx, 3 upgrade, 4 flush, 5 optional flush |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | Shared-sense drive for the snoop |
| snp_flush | output | 1 | Supply of a dirty line |
| snp_flushopt | output | 1 | Optional supply of a clean exclusive line |

## Verification
The bench builds two copies with two index bits and two tag bits, so four lines and four tags per line. One copy has optional supply enabled and the other has it disabled, and both get the same stimulus. Because the configuration is this small, every line index, every start state (Invalid, Shared, Exclusive, Modified) and every snooped command can be swept. In each case the bench checks the response, compares the two copies and probes the resulting state with a write. Directed sequences then cover dirty and clean eviction, write hits, and the race where an upgrade loses its line before the grant.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_st_e;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_RD       = 3'd1,
        CMD_RDX      = 3'd2,
        CMD_UPGR     = 3'd3,
        CMD_FLUSH    = 3'd4,
        CMD_FLUSHOPT = 3'd5
    } bus_cmd_e;

endpackage

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int FLUSHOPT_EN = 1
) (
    input  logic     hit,
    input  line_st_e cur,
    input  logic [2:0] cmd,
    output line_st_e nxt,
    output logic     flush,
    output logic     flushopt,
    output logic     shared
);
    localparam logic OPT_ON = (FLUSHOPT_EN != 0);

    logic clean_supply;

    always_comb begin
        nxt          = cur;
        flush        = 1'b0;
        shared       = 1'b0;
        clean_supply = 1'b0;
        if (hit && cur != ST_I) begin
            case (bus_cmd_e'(cmd))
                CMD_RD: begin
                    shared = 1'b1;
                    if (cur == ST_M) begin
                        flush = 1'b1;
                        nxt   = ST_S;
                    end else if (cur == ST_E) begin
                        clean_supply = 1'b1;
                        nxt          = ST_S;
                    end
                end
                CMD_RDX, CMD_UPGR: begin
                    flush = (cur == ST_M);
                    nxt   = ST_I;
                end
                default: begin
                    nxt = cur;
                end
            endcase
        end
    end

    assign flushopt = clean_supply & OPT_ON;

endmodule

// File: rtl/mesi_cpu_decide.sv
module mesi_cpu_decide
    import mesi_pkg::*;
(
    input  logic     hit,
    input  line_st_e cur,
    input  logic     write,
    output logic     done_now,
    output line_st_e hit_nxt,
    output bus_cmd_e cmd,
    output logic     evict_wb
);
    always_comb begin
        done_now = 1'b0;
        hit_nxt  = cur;
        cmd      = CMD_NONE;
        evict_wb = 1'b0;
        if (hit) begin
            if (!write) begin
                done_now = 1'b1;
            end else if (cur == ST_M || cur == ST_E) begin
                done_now = 1'b1;
                hit_nxt  = ST_M;
            end else begin
                cmd = CMD_UPGR;
            end
        end else begin
            cmd      = write ? CMD_RDX : CMD_RD;
            evict_wb = (cur == ST_M);
        end
    end
endmodule

// File: rtl/mesi_line_ctl.sv
module mesi_line_ctl
    import mesi_pkg::*;
#(
    parameter int IDX_W       = 4,
    parameter int TAG_W       = 8,
    parameter int FLUSHOPT_EN = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cpu_valid,
    input  logic                   cpu_write,
    input  logic [IDX_W+TAG_W-1:0] cpu_addr,
    output logic                   cpu_done,
    output logic                   bus_req_valid,
    output logic [2:0]             bus_req_cmd,
    output logic [IDX_W+TAG_W-1:0] bus_req_addr,
    input  logic                   bus_gnt,
    input  logic                   bus_shared_in,
    output logic                   wb_valid,
    output logic [IDX_W+TAG_W-1:0] wb_addr,
    input  logic                   snp_valid,
    input  logic [2:0]             snp_cmd,
    input  logic [IDX_W+TAG_W-1:0] snp_addr,
    output logic                   snp_shared,
    output logic                   snp_flush,
    output logic                   snp_flushopt
);
    localparam int ADDR_W = IDX_W + TAG_W;
    localparam int NLINES = 1 << IDX_W;

    typedef struct packed {
        logic [NLINES-1:0][1:0]       st;
        logic [NLINES-1:0][TAG_W-1:0] tag;
        logic                         waiting;
        logic                         pend_write;
        logic [2:0]                   pend_cmd;
        logic [ADDR_W-1:0]            pend_addr;
        logic                         done;
        logic                         wb_valid;
        logic [ADDR_W-1:0]            wb_addr;
        logic                         snp_shared;
        logic                         snp_flush;
        logic                         snp_flushopt;
    } ctl_t;

    ctl_t d, q;

    // snoop-side lookup
    logic [IDX_W-1:0] s_idx;
    logic [TAG_W-1:0] s_tag;
    line_st_e         s_cur;
    logic             s_hit;
    line_st_e         s_nxt;
    logic             s_flush, s_flushopt, s_shared;

    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];
    assign s_cur = line_st_e'(q.st[s_idx]);
    assign s_hit = snp_valid && (q.tag[s_idx] == s_tag) && (s_cur != ST_I);

    mesi_snoop_resp #(
        .FLUSHOPT_EN(FLUSHOPT_EN)
    ) u_snoop (
        .hit      (s_hit),
        .cur      (s_cur),
        .cmd      (snp_cmd),
        .nxt      (s_nxt),
        .flush    (s_flush),
        .flushopt (s_flushopt),
        .shared   (s_shared)
    );

    // processor-side lookup
    logic [IDX_W-1:0] c_idx;
    logic [TAG_W-1:0] c_tag;
    line_st_e         c_cur;
    logic             c_hit;
    logic             c_done_now;
    line_st_e         c_hit_nxt;
    bus_cmd_e         c_cmd;
    logic             c_evict_wb;

    assign c_idx = cpu_addr[IDX_W-1:0];
    assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign c_cur = line_st_e'(q.st[c_idx]);
    assign c_hit = (q.tag[c_idx] == c_tag) && (c_cur != ST_I);

    mesi_cpu_decide u_decide (
        .hit      (c_hit),
        .cur      (c_cur),
        .write    (cpu_write),
        .done_now (c_done_now),
        .hit_nxt  (c_hit_nxt),
        .cmd      (c_cmd),
        .evict_wb (c_evict_wb)
    );

    // pending request fields
    logic [IDX_W-1:0] p_idx;
    logic [TAG_W-1:0] p_tag;
    logic             snp_kills_pend;

    assign p_idx = q.pend_addr[IDX_W-1:0];
    assign p_tag = q.pend_addr[ADDR_W-1:IDX_W];
    assign snp_kills_pend = s_hit && (snp_addr == q.pend_addr) &&
                            (snp_cmd == CMD_RDX || snp_cmd == CMD_UPGR);

    always_comb begin
        d              = q;
        d.done         = 1'b0;
        d.wb_valid     = 1'b0;
        d.snp_shared   = 1'b0;
        d.snp_flush    = 1'b0;
        d.snp_flushopt = 1'b0;

        // snoop side first; a processor fill below wins on the same line
        if (snp_valid) begin
            d.st[s_idx]    = s_nxt;
            d.snp_shared   = s_shared;
            d.snp_flush    = s_flush;
            d.snp_flushopt = s_flushopt;
            if (q.waiting && q.pend_cmd == CMD_UPGR && snp_kills_pend) begin
                d.pend_cmd = CMD_RDX;
            end
        end

        if (!q.waiting) begin
            if (cpu_valid && !snp_valid) begin
                if (c_done_now) begin
                    d.done       = 1'b1;
                    d.st[c_idx]  = c_hit_nxt;
                end else begin
                    d.waiting    = 1'b1;
                    d.pend_cmd   = c_cmd;
                    d.pend_addr  = cpu_addr;
                    d.pend_write = cpu_write;
                    if (!c_hit) begin
                        d.wb_valid   = c_evict_wb;
                        d.wb_addr    = {q.tag[c_idx], c_idx};
                        d.st[c_idx]  = ST_I;
                        d.tag[c_idx] = c_tag;
                    end
                end
            end
        end else if (bus_gnt) begin
            if (q.pend_write) begin
                d.st[p_idx] = ST_M;
            end else begin
                d.st[p_idx] = bus_shared_in ? ST_S : ST_E;
            end
            d.tag[p_idx] = p_tag;
            d.waiting    = 1'b0;
            d.pend_cmd   = CMD_NONE;
            d.done       = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_done      = q.done;
    assign bus_req_valid = q.waiting;
    assign bus_req_cmd   = q.pend_cmd;
    assign bus_req_addr  = q.pend_addr;
    assign wb_valid      = q.wb_valid;
    assign wb_addr       = q.wb_addr;
    assign snp_shared    = q.snp_shared;
    assign snp_flush     = q.snp_flush;
    assign snp_flushopt  = q.snp_flushopt;

    // assertions
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.waiting && !bus_gnt) |=> q.waiting); // R3
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> !q.waiting); // R2
    AST_WB_WITH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        q.wb_valid |-> (q.waiting && (q.pend_cmd == CMD_RD || q.pend_cmd == CMD_RDX))); // R6
    AST_ONE_SUPPLIER: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.snp_flush && q.snp_flushopt)); // R7
    AST_OPT_WITH_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        q.snp_flushopt |-> q.snp_shared); // R7
    AST_OPT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (FLUSHOPT_EN == 0) |-> !q.snp_flushopt); // R10
    AST_UPGR_ON_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.waiting && q.pend_cmd == CMD_UPGR) |-> (q.st[p_idx] == ST_S)); // R11

endmodule

// File: tb/sim_mesi_line_ctl.sv
module sim_mesi_line_ctl;
    localparam int IW = 2;
    localparam int TW = 2;
    localparam int AW = IW + TW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          cpu_valid = 0, cpu_write = 0;
    logic [AW-1:0] cpu_addr = '0;
    logic          bus_gnt = 0, bus_shared_in = 0;
    logic          snp_valid = 0;
    logic [2:0]    snp_cmd = '0;
    logic [AW-1:0] snp_addr = '0;

    logic          o_done, o_req, o_wb, o_sh, o_fl, o_fo;
    logic [2:0]    o_cmd;
    logic [AW-1:0] o_raddr, o_wba;
    logic          p_done, p_req, p_wb, p_sh, p_fl, p_fo;
    logic [2:0]    p_cmd;
    logic [AW-1:0] p_raddr, p_wba;

    mesi_line_ctl #(.IDX_W(IW), .TAG_W(TW), .FLUSHOPT_EN(1)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_done(o_done), .bus_req_valid(o_req),
        .bus_req_cmd(o_cmd), .bus_req_addr(o_raddr), .bus_gnt(bus_gnt),
        .bus_shared_in(bus_shared_in), .wb_valid(o_wb), .wb_addr(o_wba),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(o_sh), .snp_flush(o_fl), .snp_flushopt(o_fo));

    mesi_line_ctl #(.IDX_W(IW), .TAG_W(TW), .FLUSHOPT_EN(0)) u1 (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
        .cpu_addr(cpu_addr), .cpu_done(p_done), .bus_req_valid(p_req),
        .bus_req_cmd(p_cmd), .bus_req_addr(p_raddr), .bus_gnt(bus_gnt),
        .bus_shared_in(bus_shared_in), .wb_valid(p_wb), .wb_addr(p_wba),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_shared(p_sh), .snp_flush(p_fl), .snp_flushopt(p_fo));

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Processor op; returns the bus command seen (0 if none) and write-back info.
    task automatic cpu_op(input logic wr, input logic [AW-1:0] a, input logic sh,
                          output int cmd, output int pcmd, output int wb, output int wba);
        @(negedge clk);
        cpu_valid = 1; cpu_write = wr; cpu_addr = a;
        @(negedge clk);
        cmd = 0; pcmd = 0; wb = 0; wba = 0;
        if (o_done) begin
            cpu_valid = 0;
        end else begin
            cmd = int'(o_cmd); pcmd = int'(p_cmd);
            wb = int'(o_wb); wba = int'(o_wba);
            chk("R3 request raised", int'(o_req), 1);
            bus_gnt = 1; bus_shared_in = sh;
            @(negedge clk);
            bus_gnt = 0; cpu_valid = 0;
            chk("R3 done after grant", int'(o_done), 1);
        end
    endtask

    task automatic snoop(input int c, input logic [AW-1:0] a,
                         output int sh, output int fl, output int fo,
                         output int psh, output int pfl, output int pfo);
        @(negedge clk);
        snp_valid = 1; snp_cmd = 3'(c); snp_addr = a;
        @(negedge clk);
        snp_valid = 0;
        sh = int'(o_sh); fl = int'(o_fl); fo = int'(o_fo);
        psh = int'(p_sh); pfl = int'(p_fl); pfo = int'(p_fo);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int cmd, pcmd, wb, wba, sh, fl, fo, psh, pfl, pfo;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done low", int'(o_done), 0);
        chk("R1 req low", int'(o_req), 0);
        chk("R1 wb low", int'(o_wb), 0);
        chk("R1 snoop outs low", int'(o_sh | o_fl | o_fo), 0);
        cpu_op(0, 4'b0000, 0, cmd, pcmd, wb, wba);
        chk("R1 first read misses", cmd, 1);
        // R2 read hit on Exclusive line
        cpu_op(0, 4'b0000, 0, cmd, pcmd, wb, wba);
        chk("R2 read hit no bus", cmd, 0);
        // R5 Exclusive write hit, then Modified write hit
        cpu_op(1, 4'b0000, 0, cmd, pcmd, wb, wba);
        chk("R5 E write silent", cmd, 0);
        cpu_op(1, 4'b0000, 0, cmd, pcmd, wb, wba);
        chk("R5 M write silent", cmd, 0);
        snoop(1, 4'b0000, sh, fl, fo, psh, pfl, pfo);
        chk("R5 line is Modified (flush)", fl, 1);

        // Sweep: index x start state x snooped command
        for (int idx = 0; idx < 4; idx++) begin
            for (int st = 0; st < 4; st++) begin          // 0 I,1 S,2 E,3 M
                for (int c = 1; c <= 5; c++) begin
                    logic [1:0] tg;
                    logic [AW-1:0] a;
                    int valid, e_sh, e_fl, e_fo, e_probe;
                    tg = 2'((idx + st + c) % 4);
                    a = {tg, 2'(idx)};
                    for (int t = 0; t < 4; t++)
                        snoop(2, {2'(t), 2'(idx)}, sh, fl, fo, psh, pfl, pfo);
                    if (st == 1) begin
                        cpu_op(0, a, 1, cmd, pcmd, wb, wba);
                        chk("R3 read miss cmd", cmd, 1);
                    end else if (st == 2) begin
                        cpu_op(0, a, 0, cmd, pcmd, wb, wba);
                        chk("R3 read miss cmd", cmd, 1);
                    end else if (st == 3) begin
                        cpu_op(1, a, 0, cmd, pcmd, wb, wba);
                        chk("R4 write miss cmd", cmd, 2);
                    end
                    valid = (st != 0);
                    // other-tag snoop: no effect
                    snoop(1, {tg + 2'd1, 2'(idx)}, sh, fl, fo, psh, pfl, pfo);
                    chk("R9 tag miss snoop silent", sh + fl + fo, 0);
                    snoop(c, a, sh, fl, fo, psh, pfl, pfo);
                    e_sh = (valid && c == 1) ? 1 : 0;
                    e_fl = (st == 3 && c >= 1 && c <= 3) ? 1 : 0;
                    e_fo = (st == 2 && c == 1) ? 1 : 0;
                    chk(c == 1 ? "R7 shared-sense" : (c <= 3 ? "R8 shared-sense" : "R9 shared-sense"), sh, e_sh);
                    chk(c == 1 ? "R7 flush" : (c <= 3 ? "R8 flush" : "R9 flush"), fl, e_fl);
                    chk(c == 1 ? "R7 flushopt" : "R9 flushopt", fo, e_fo);
                    chk("R10 flushopt off", pfo, 0);
                    chk("R10 shared same", psh, e_sh);
                    chk("R10 flush same", pfl, e_fl);
                    // probe resulting state with a write
                    if (!valid || c == 2 || c == 3) e_probe = 2;             // Invalid
                    else if (c == 1 || st == 1) e_probe = 3;                 // Shared
                    else e_probe = 0;                                        // E or M
                    cpu_op(1, a, 0, cmd, pcmd, wb, wba);
                    chk(e_probe == 3 ? "R4 upgrade from Shared" :
                        (e_probe == 0 ? "R5 silent write" : "R8 invalidated"), cmd, e_probe);
                    chk("R10 probe same", pcmd, e_probe);
                end
            end
        end

        // R6 eviction
        for (int t = 0; t < 4; t++)
            snoop(2, {2'(t), 2'd1}, sh, fl, fo, psh, pfl, pfo);
        cpu_op(1, {2'd1, 2'd1}, 0, cmd, pcmd, wb, wba);
        cpu_op(0, {2'd2, 2'd1}, 0, cmd, pcmd, wb, wba);
        chk("R6 dirty victim cmd", cmd, 1);
        chk("R6 dirty victim wb", wb, 1);
        chk("R6 victim address", wba, 5);
        cpu_op(0, {2'd3, 2'd1}, 1, cmd, pcmd, wb, wba);
        chk("R6 clean E victim no wb", wb, 0);
        cpu_op(0, {2'd0, 2'd1}, 0, cmd, pcmd, wb, wba);
        chk("R6 clean S victim no wb", wb, 0);
        cpu_op(0, {2'd3, 2'd1}, 0, cmd, pcmd, wb, wba);
        chk("R6 evicted line misses", cmd, 1);

        // R11 upgrade loses its line before the grant
        for (int t = 0; t < 4; t++)
            snoop(2, {2'(t), 2'd2}, sh, fl, fo, psh, pfl, pfo);
        cpu_op(0, {2'd1, 2'd2}, 1, cmd, pcmd, wb, wba);
        @(negedge clk);
        cpu_valid = 1; cpu_write = 1; cpu_addr = {2'd1, 2'd2};
        @(negedge clk);
        chk("R11 upgrade issued", int'(o_cmd), 3);
        snp_valid = 1; snp_cmd = 3'd3; snp_addr = {2'd1, 2'd2};
        @(negedge clk);
        snp_valid = 0;
        chk("R11 converted to rdx", int'(o_cmd), 2);
        chk("R11 still requesting", int'(o_req), 1);
        bus_gnt = 1; bus_shared_in = 0;
        @(negedge clk);
        bus_gnt = 0; cpu_valid = 0;
        chk("R11 done", int'(o_done), 1);
        snoop(1, {2'd1, 2'd2}, sh, fl, fo, psh, pfl, pfo);
        chk("R11 filled Modified", fl, 1);

        // R12 processor request stalls behind a snoop
        @(negedge clk);
        cpu_valid = 1; cpu_write = 0; cpu_addr = {2'd1, 2'd2};
        snp_valid = 1; snp_cmd = 3'd4; snp_addr = 4'd0;
        @(negedge clk);
        snp_valid = 0;
        chk("R12 stalled by snoop", int'(o_done), 0);
        @(negedge clk);
        cpu_valid = 0;
        chk("R12 taken next cycle", int'(o_done), 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule